// File: doc/BRIEF.md
# Multi-Level Radix Table Walker

This block turns an effective address into a real address by walking a tree of page directories held in memory. A walk begins with a start pulse. The pulse carries the effective address, the root directory base, the root index width and the total translated width. At each level the walker takes a slice of the effective address and uses it to pick an 8-byte entry in the current directory. It fetches that entry through a simple 64-bit read port. The entry either points one level deeper or is a leaf that names the page.

Each non-leaf entry can change the index width used at the next level. The walker enforces a fixed set of legal widths per level, and it checks the level's legality before each read, so an illegal configuration never reaches memory. A walk ends in one of three ways. It completes with the real address, page width and leaf entry. It stops with a no-entry fault when an entry is not valid. It stops with a bad-configuration fault when a level's widths are illegal. Only one read is outstanding at a time, and start pulses that arrive while a walk is under way are dropped.

Top module: `radix_walker`

## Requirements
- R1: After reset `busy`, `done`, `fault` and `mem_req` are low and `fault_kind` is 0.
- R2: A start pulse while idle begins a walk. Each read is a one-cycle `mem_req` pulse, and no new request is issued before the previous response has returned. The first read goes to `root_base` with its low (`root_isz`+3) bits cleared, plus 8 times the index. The index is `(ea >> (total_size - root_isz))` masked to `root_isz` bits.
- R3: Level legality is checked before the read at that level. Level 0 needs a total width of 52 and an index width of 13. Levels 1 and 2 need 9. Level 3 accepts 9 or 5. A walk that reaches level 4 is illegal. An illegal level ends the walk with `fault_kind` = 2 and issues no read for that level.
- R4: A fetched entry with bit 63 clear ends the walk with `fault_kind` = 2'd1.
- R5: A valid entry with bit 62 clear is a pointer. Bits 59:8 of the entry, with bits 7:0 taken as zero, give the next base. Bits 4:0 give the next index width. Every fetched valid entry reduces the remaining width by the current index width.
- R6: A valid entry with bit 62 set is a leaf. `page_size` becomes the remaining width. `real_addr` is entry bits 56:12 (kept in place), with the low `page_size` bits replaced by those of `ea`. `leaf_entry` is the whole entry, and `done` pulses.
- R7: Base address bits below 2^(index width + 3) are forced to zero. This applies to the root base and to every next-level base, and no fault is raised for them.
- R8: A start pulse while `busy` is high is ignored, including in the cycle where `done` or `fault` is high. It neither changes the result nor issues any read.
- R9: `done` and `fault` are one-cycle pulses and are never high together. `real_addr`, `page_size` and `leaf_entry` hold until the next successful walk, and a faulting walk leaves them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a walk (sampled while idle) |
| ea | input | 64 | Effective address to translate |
| root_base | input | 64 | Root directory base |
| root_isz | input | 5 | Root index width |
| total_size | input | 6 | Total translated width |
| mem_req | output | 1 | Read request pulse |
| mem_addr | output | 64 | Read address (8-byte aligned) |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Read data |
| busy | output | 1 | Walk in progress |
| done | output | 1 | Successful walk pulse |
| fault | output | 1 | Faulting walk pulse |
| fault_kind | output | 2 | 0 none, 1 no entry, 2 bad configuration |
| real_addr | output | 64 | Translated address |
| page_size | output | 6 | Page width in bits |
| leaf_entry | output | 64 | Leaf entry of the last successful walk |

## Verification
Two things can land in the same cycle: a fresh start pulse and the completion of the current walk. The same holds for a start pulse arriving in the middle of an outstanding read. The bench raises `start` with a different address while a read is waiting. It raises it again in the exact cycle where `done` is seen. It then judges that the result still matches the first address, that the read count equals the reference model's, and that `busy` stays low afterwards. A second overlap arises when a misaligned base has its low bits cleared while an index is added at the same level. The sweeps cover this with misaligned root and pointer bases and compare each first read address.

// File: rtl/radix_walk_pkg.sv
`timescale 1ns/1ps
package radix_walk_pkg;

  localparam int unsigned ENT_W   = 64;
  localparam int unsigned ISZ_W   = 5;
  localparam int unsigned REM_W   = 7;
  localparam int unsigned PSZ_W   = REM_W - 1;
  localparam int unsigned VALID_B = 63;
  localparam int unsigned LEAF_B  = 62;

  localparam logic [ENT_W-1:0] NEXT_BASE_FIELD = 64'h0FFF_FFFF_FFFF_FF00;
  localparam logic [ENT_W-1:0] PAGE_NUM_FIELD  = 64'h01FF_FFFF_FFFF_F000;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CHECK, ST_READ, ST_WAIT, ST_DECIDE, ST_DONE, ST_FAULT
  } walk_state_e;

  typedef enum logic [1:0] {
    FK_NONE     = 2'd0,
    FK_NO_ENTRY = 2'd1,
    FK_BAD_CFG  = 2'd2
  } fault_kind_e;

  // mask of the n lowest bits, saturating at a full word
  function automatic logic [ENT_W-1:0] ones_below(input logic [REM_W-1:0] n);
    if (n >= REM_W'(ENT_W)) return '1;
    return (64'd1 << n) - 64'd1;
  endfunction

  // slice of the effective address used to pick an entry in this level
  function automatic logic [ENT_W-1:0] level_index(input logic [ENT_W-1:0] ea,
                                                   input logic [REM_W-1:0] rem,
                                                   input logic [ISZ_W-1:0] isz);
    logic [REM_W-1:0] sh;
    sh = (rem >= {2'b00, isz}) ? rem - {2'b00, isz} : '0;
    return (ea >> sh) & ones_below({2'b00, isz});
  endfunction

  // aligned base plus eight bytes per index step
  function automatic logic [ENT_W-1:0] slot_address(input logic [ENT_W-1:0] base,
                                                    input logic [ENT_W-1:0] idx,
                                                    input logic [ISZ_W-1:0] isz);
    return (base & ~ones_below({2'b00, isz} + REM_W'(3))) + (idx << 3);
  endfunction

  // page number high bits joined with the in-page offset of the address
  function automatic logic [ENT_W-1:0] splice_real(input logic [ENT_W-1:0] entry,
                                                   input logic [ENT_W-1:0] ea,
                                                   input logic [REM_W-1:0] rem);
    logic [ENT_W-1:0] m;
    m = ones_below(rem);
    return ((entry & PAGE_NUM_FIELD) & ~m) | (ea & m);
  endfunction

endpackage

// File: rtl/rw_level_rules.sv
`timescale 1ns/1ps
module rw_level_rules
  import radix_walk_pkg::*;
#(
  parameter int unsigned MAX_LEVEL    = 3,
  parameter int unsigned LVL_W        = 3,
  parameter int unsigned ROOT_TOTAL   = 52,
  parameter int unsigned ROOT_ISZ     = 13,
  parameter int unsigned MID_ISZ      = 9,
  parameter int unsigned TAIL_ALT_ISZ = 5
) (
  input  logic [LVL_W-1:0] level,
  input  logic [REM_W-1:0] remaining,
  input  logic [ISZ_W-1:0] isz,
  output logic             legal
);

  logic [MAX_LEVEL:0] lvl_ok;

  for (genvar g = 0; g <= MAX_LEVEL; g++) begin : g_rule
    if (g == 0) begin : g_root
      assign lvl_ok[g] = (remaining == REM_W'(ROOT_TOTAL)) && (isz == ISZ_W'(ROOT_ISZ));
    end else if (g < MAX_LEVEL) begin : g_mid
      assign lvl_ok[g] = (isz == ISZ_W'(MID_ISZ));
    end else begin : g_tail
      assign lvl_ok[g] = (isz == ISZ_W'(MID_ISZ)) || (isz == ISZ_W'(TAIL_ALT_ISZ));
    end
  end

  always_comb begin
    legal = 1'b0;
    for (int i = 0; i <= MAX_LEVEL; i++) begin
      if (level == LVL_W'(i)) legal = lvl_ok[i];
    end
  end

endmodule

// File: rtl/rw_slot_addr.sv
`timescale 1ns/1ps
module rw_slot_addr
  import radix_walk_pkg::*;
(
  input  logic [ENT_W-1:0] ea,
  input  logic [ENT_W-1:0] base,
  input  logic [REM_W-1:0] remaining,
  input  logic [ISZ_W-1:0] isz,
  output logic [ENT_W-1:0] slot
);

  logic [ENT_W-1:0] idx;

  always_comb begin
    idx  = level_index(ea, remaining, isz);
    slot = slot_address(base, idx, isz);
  end

endmodule

// File: rtl/rw_leaf_form.sv
`timescale 1ns/1ps
module rw_leaf_form
  import radix_walk_pkg::*;
(
  input  logic [ENT_W-1:0] entry,
  input  logic [ENT_W-1:0] ea,
  input  logic [REM_W-1:0] remaining,
  output logic [ENT_W-1:0] real_out
);

  always_comb real_out = splice_real(entry, ea, remaining);

endmodule

// File: rtl/radix_walker.sv
`timescale 1ns/1ps
module radix_walker
  import radix_walk_pkg::*;
#(
  parameter int unsigned MAX_LEVEL    = 3,
  parameter int unsigned ROOT_TOTAL   = 52,
  parameter int unsigned ROOT_ISZ     = 13,
  parameter int unsigned MID_ISZ      = 9,
  parameter int unsigned TAIL_ALT_ISZ = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [63:0]      ea,
  input  logic [63:0]      root_base,
  input  logic [4:0]       root_isz,
  input  logic [5:0]       total_size,
  output logic             mem_req,
  output logic [63:0]      mem_addr,
  input  logic             mem_rsp_valid,
  input  logic [63:0]      mem_rsp_data,
  output logic             busy,
  output logic             done,
  output logic             fault,
  output logic [1:0]       fault_kind,
  output logic [63:0]      real_addr,
  output logic [5:0]       page_size,
  output logic [63:0]      leaf_entry
);

  localparam int unsigned LVL_W = $clog2(MAX_LEVEL + 2);

  walk_state_e      state_q;
  logic [ENT_W-1:0] ea_q, base_q, entry_q, addr_q;
  logic [ISZ_W-1:0] isz_q;
  logic [REM_W-1:0] rem_q, rem_next;
  logic [LVL_W-1:0] level_q;
  logic [ENT_W-1:0] real_q, leaf_q;
  logic [PSZ_W-1:0] psize_q;
  fault_kind_e      kind_q;

  logic             lvl_legal;
  logic [ENT_W-1:0] slot_addr, leaf_real;

  // named internal events, watched by the checker
  logic ev_cfg_bad, ev_issue, ev_rsp_take, ev_no_entry, ev_leaf, ev_descend;

  assign rem_next    = rem_q - {2'b00, isz_q};
  assign ev_cfg_bad  = (state_q == ST_CHECK) && !lvl_legal;
  assign ev_issue    = (state_q == ST_READ);
  assign ev_rsp_take = (state_q == ST_WAIT) && mem_rsp_valid;
  assign ev_no_entry = (state_q == ST_DECIDE) && !entry_q[VALID_B];
  assign ev_leaf     = (state_q == ST_DECIDE) && entry_q[VALID_B] && entry_q[LEAF_B];
  assign ev_descend  = (state_q == ST_DECIDE) && entry_q[VALID_B] && !entry_q[LEAF_B];

  rw_level_rules #(
    .MAX_LEVEL   (MAX_LEVEL),
    .LVL_W       (LVL_W),
    .ROOT_TOTAL  (ROOT_TOTAL),
    .ROOT_ISZ    (ROOT_ISZ),
    .MID_ISZ     (MID_ISZ),
    .TAIL_ALT_ISZ(TAIL_ALT_ISZ)
  ) u_rules (
    .level    (level_q),
    .remaining(rem_q),
    .isz      (isz_q),
    .legal    (lvl_legal)
  );

  rw_slot_addr u_slot (
    .ea       (ea_q),
    .base     (base_q),
    .remaining(rem_q),
    .isz      (isz_q),
    .slot     (slot_addr)
  );

  rw_leaf_form u_leaf (
    .entry    (entry_q),
    .ea       (ea_q),
    .remaining(rem_next),
    .real_out (leaf_real)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ea_q    <= '0;
      base_q  <= '0;
      entry_q <= '0;
      addr_q  <= '0;
      isz_q   <= '0;
      rem_q   <= '0;
      level_q <= '0;
      real_q  <= '0;
      leaf_q  <= '0;
      psize_q <= '0;
      kind_q  <= FK_NONE;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            ea_q    <= ea;
            base_q  <= root_base;
            isz_q   <= root_isz;
            rem_q   <= {1'b0, total_size};
            level_q <= '0;
            state_q <= ST_CHECK;
          end
        end
        ST_CHECK: begin
          if (lvl_legal) begin
            addr_q  <= slot_addr;
            state_q <= ST_READ;
          end else begin
            kind_q  <= FK_BAD_CFG;
            state_q <= ST_FAULT;
          end
        end
        ST_READ: state_q <= ST_WAIT;
        ST_WAIT: begin
          if (mem_rsp_valid) begin
            entry_q <= mem_rsp_data;
            state_q <= ST_DECIDE;
          end
        end
        ST_DECIDE: begin
          if (!entry_q[VALID_B]) begin
            kind_q  <= FK_NO_ENTRY;
            state_q <= ST_FAULT;
          end else begin
            rem_q <= rem_next;
            if (entry_q[LEAF_B]) begin
              real_q  <= leaf_real;
              psize_q <= rem_next[PSZ_W-1:0];
              leaf_q  <= entry_q;
              kind_q  <= FK_NONE;
              state_q <= ST_DONE;
            end else begin
              base_q  <= entry_q & NEXT_BASE_FIELD;
              isz_q   <= entry_q[ISZ_W-1:0];
              level_q <= level_q + LVL_W'(1);
              state_q <= ST_CHECK;
            end
          end
        end
        ST_DONE:  state_q <= ST_IDLE;
        ST_FAULT: state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_req    = ev_issue;
  assign mem_addr   = addr_q;
  assign busy       = (state_q != ST_IDLE);
  assign done       = (state_q == ST_DONE);
  assign fault      = (state_q == ST_FAULT);
  assign fault_kind = kind_q;
  assign real_addr  = real_q;
  assign page_size  = psize_q;
  assign leaf_entry = leaf_q;

endmodule

// File: rtl/rw_checker.sv
`timescale 1ns/1ps
module rw_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        busy,
  input logic        done,
  input logic        fault,
  input logic [1:0]  fault_kind,
  input logic        mem_req,
  input logic [63:0] mem_addr,
  input logic [63:0] real_addr,
  input logic        ev_cfg_bad,
  input logic        ev_no_entry,
  input logic        ev_leaf
);

  p_req_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

  p_req_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy);

  p_req_align_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[2:0] == 3'b000));

  p_badcfg_noread_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_cfg_bad |=> (fault && fault_kind == 2'd2 && !mem_req));

  p_noentry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_no_entry |=> (fault && fault_kind == 2'd1));

  p_leaf_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_leaf |=> (done && fault_kind == 2'd0));

  p_start_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fault));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_fault_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> !fault);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_leaf |=> $stable(real_addr));

endmodule

bind radix_walker rw_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .busy       (busy),
  .done       (done),
  .fault      (fault),
  .fault_kind (fault_kind),
  .mem_req    (mem_req),
  .mem_addr   (mem_addr),
  .real_addr  (real_addr),
  .ev_cfg_bad (ev_cfg_bad),
  .ev_no_entry(ev_no_entry),
  .ev_leaf    (ev_leaf)
);

// File: tb/radix_walker_test.sv
`timescale 1ns/1ps
module radix_walker_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [63:0] ea_i = '0, base_i = '0;
  logic [4:0]  isz_i = '0;
  logic [5:0]  tot_i = '0;
  logic        mem_req, mem_rsp_valid = 1'b0;
  logic [63:0] mem_addr, mem_rsp_data = '0;
  logic        busy, done, fault;
  logic [1:0]  fault_kind;
  logic [63:0] real_addr, leaf_entry;
  logic [5:0]  page_size;

  always #4 clk = ~clk;

  radix_walker uut (
    .clk(clk), .rst_n(rst_n), .start(start), .ea(ea_i), .root_base(base_i),
    .root_isz(isz_i), .total_size(tot_i), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .busy(busy),
    .done(done), .fault(fault), .fault_kind(fault_kind), .real_addr(real_addr),
    .page_size(page_size), .leaf_entry(leaf_entry)
  );

  // ---------------- memory model ----------------
  logic [63:0] mem [logic [63:0]];
  int          lat_sel = 0;
  logic        pend = 1'b0;
  int          cnt = 0;
  logic [63:0] raddr_l = '0;
  logic [31:0] nreads = '0;
  logic [63:0] req_hist [0:15];

  always @(posedge clk) begin
    mem_rsp_valid <= 1'b0;
    if (pend) begin
      if (cnt == 0) begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_data  <= mem.exists(raddr_l) ? mem[raddr_l] : 64'h0;
        pend          <= 1'b0;
      end else cnt <= cnt - 1;
    end
    if (rst_n && mem_req) begin
      pend    <= 1'b1;
      cnt     <= lat_sel;
      raddr_l <= mem_addr;
      req_hist[nreads[3:0]] <= mem_addr;
      nreads  <= nreads + 1;
    end
  end

  // ---------------- bookkeeping ----------------
  int n_tests = 0;
  int n_fail  = 0;

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", what, act, exp);
    end
  endtask

  localparam logic [63:0] RB   = 64'h0000_0000_0040_0000;
  localparam logic [63:0] LEAF = 64'hC0AB_CDEF_1234_518B;
  logic [63:0] paddr [0:3];

  function automatic logic [63:0] p2(input int n);
    return 64'd1 << n;
  endfunction

  // independent model of a walk, reading the bench memory
  task automatic ref_walk(input logic [63:0] ea, input logic [63:0] base, input int isz,
                          input int tot, output int kind, output logic [63:0] ra,
                          output int ps, output logic [63:0] lf, output int reads);
    int rem, cur;
    logic [63:0] b, e, a, idx;
    bit ok;
    rem = tot; cur = isz; b = base;
    kind = 0; ra = '0; ps = 0; lf = '0; reads = 0;
    for (int lvl = 0; lvl < 8; lvl++) begin
      case (lvl)
        0:       ok = (rem == 52) && (cur == 13);
        1, 2:    ok = (cur == 9);
        3:       ok = (cur == 9) || (cur == 5);
        default: ok = 1'b0;
      endcase
      if (!ok) begin kind = 2; return; end
      idx = (ea / p2(rem - cur)) % p2(cur);
      a = (b / p2(cur + 3)) * p2(cur + 3) + idx * 8;
      e = mem.exists(a) ? mem[a] : 64'h0;
      reads++;
      if (!e[63]) begin kind = 1; return; end
      rem = rem - cur;
      if (e[62]) begin
        ps = rem; lf = e;
        ra = ((e / p2(12)) % p2(45)) * p2(12);
        ra = (ra / p2(rem)) * p2(rem) + (ea % p2(rem));
        return;
      end
      b = ((e / p2(8)) % p2(52)) * p2(8);
      cur = int'(e[4:0]);
    end
    kind = 2;
  endtask

  // lays down one path through the tree for address ea
  task automatic build(input logic [63:0] ea, input int leaf_lvl, input int l3isz,
                       input logic [63:0] mis);
    int rem, cur, nxt;
    logic [63:0] b, a, db;
    mem.delete();
    rem = 52; cur = 13; b = RB;
    for (int lvl = 0; lvl <= leaf_lvl; lvl++) begin
      a = b + (((ea >> (rem - cur)) & (p2(cur) - 1)) << 3);
      paddr[lvl] = a;
      rem = rem - cur;
      if (lvl == leaf_lvl) begin
        mem[a] = LEAF;
      end else begin
        nxt = (lvl == 2) ? l3isz : 9;
        db  = 64'h0100_0000 * 64'(lvl + 1);
        mem[a] = 64'h8000_0000_0000_0000 | db | ((nxt == 9) ? mis : 64'h0) | 64'(nxt);
        b = db; cur = nxt;
      end
    end
  endtask

  int          o_kind, o_reads;
  logic        o_done;
  logic [63:0] o_real, o_leaf, o_first;
  int          o_ps;

  task automatic run_walk(input logic [63:0] a, input logic [63:0] b, input int isz, input int tot);
    logic [31:0] r0;
    int t;
    @(negedge clk);
    r0 = nreads;
    ea_i = a; base_i = b; isz_i = 5'(isz); tot_i = 6'(tot); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    t = 0;
    while (!(done || fault) && t < 400) begin @(negedge clk); t++; end
    if (t >= 400) chk("R9 walk completes", 64'd0, 64'd1);
    o_done = done; o_kind = int'(fault_kind); o_real = real_addr;
    o_ps = int'(page_size); o_leaf = leaf_entry; o_reads = int'(nreads - r0);
    o_first = req_hist[r0[3:0]];
  endtask

  task automatic run_cmp(input string tag, input logic [63:0] a, input logic [63:0] b,
                         input int isz, input int tot);
    int ek, eps, er;
    logic [63:0] era, elf, efa;
    ref_walk(a, b, isz, tot, ek, era, eps, elf, er);
    run_walk(a, b, isz, tot);
    chk({tag, " fault_kind"}, 64'(o_kind), 64'(ek));
    chk("R9 done versus fault", 64'(o_done), 64'(ek == 0));
    chk({tag, " R2 R3 read count"}, 64'(o_reads), 64'(er));
    if (ek == 0) begin
      chk("R6 real_addr", o_real, era);
      chk("R6 page_size", 64'(o_ps), 64'(eps));
      chk("R6 leaf_entry", o_leaf, elf);
    end
    if (isz == 13 && tot == 52) begin
      efa = (b / p2(16)) * p2(16) + ((a / p2(39)) % p2(13)) * 8;
      chk("R2 R7 first read address", o_first, efa);
    end
  endtask

  logic [63:0] eas [0:3];

  initial begin
    eas[0] = 64'h000F_EDCB_A987_6543;
    eas[1] = 64'h0001_2345_6789_ABCD;
    eas[2] = 64'h0000_0000_0000_0000;
    eas[3] = 64'h000F_FFFF_FFFF_FFFF;

    repeat (3) @(negedge clk);
    chk("R1 busy in reset", 64'(busy), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy after reset", 64'(busy), 64'd0);
    chk("R1 done after reset", 64'(done), 64'd0);
    chk("R1 fault after reset", 64'(fault), 64'd0);
    chk("R1 mem_req after reset", 64'(mem_req), 64'd0);
    chk("R1 fault_kind after reset", 64'(fault_kind), 64'd0);

    // sweep: addresses x leaf depth / tail width, misaligned bases, latencies
    for (int i = 0; i < 4; i++) begin
      for (int j = 0; j < 5; j++) begin
        lat_sel = (i + j) % 3;
        build(eas[i], (j < 4) ? j : 3, (j == 4) ? 5 : 9, (j % 2 == 1) ? 64'h300 : 64'h0);
        run_cmp("R5 R6 R7", eas[i], RB | ((i == 1) ? 64'h1238 : 64'h0), 13, 52);
      end
    end

    // invalid entry at each depth
    for (int k = 0; k < 4; k++) begin
      lat_sel = k % 3;
      build(eas[k], 3, 9, 64'h0);
      mem[paddr[k]] = mem[paddr[k]] & ~(64'h1 << 63);
      run_cmp("R4", eas[k], RB, 13, 52);
    end

    // illegal configurations
    build(eas[0], 3, 9, 64'h0);
    run_cmp("R3 root width", eas[0], RB, 12, 52);
    run_cmp("R3 total width", eas[0], RB, 13, 48);
    mem[paddr[0]] = (mem[paddr[0]] & ~64'h1F) | 64'd8;
    run_cmp("R3 level1 width", eas[0], RB, 13, 52);
    build(eas[1], 3, 7, 64'h0);
    run_cmp("R3 level3 width", eas[1], RB, 13, 52);
    build(eas[2], 3, 9, 64'h0);
    mem[paddr[3]] = (mem[paddr[3]] & ~(64'h1 << 62) & ~64'h1F) | 64'd9;
    run_cmp("R3 level4", eas[2], RB, 13, 52);

    // R8: start while a read is pending and in the done cycle
    begin
      int ek, eps, er, t;
      logic [63:0] era, elf;
      logic [31:0] r0;
      lat_sel = 3;
      build(eas[0], 3, 9, 64'h0);
      ref_walk(eas[0], RB, 13, 52, ek, era, eps, elf, er);
      @(negedge clk);
      r0 = nreads;
      ea_i = eas[0]; base_i = RB; isz_i = 5'd13; tot_i = 6'd52; start = 1'b1;
      @(negedge clk); start = 1'b0;
      repeat (3) @(negedge clk);
      ea_i = eas[3]; start = 1'b1;
      @(negedge clk); start = 1'b0;
      t = 0;
      while (!done && t < 400) begin @(negedge clk); t++; end
      chk("R8 result after mid-walk start", real_addr, era);
      start = 1'b1;
      @(negedge clk); start = 1'b0;
      @(negedge clk);
      chk("R8 busy after start in done cycle", 64'(busy), 64'd0);
      chk("R8 reads unchanged by ignored starts", 64'(nreads - r0), 64'(er));
      chk("R9 done is a pulse", 64'(done), 64'd0);
    end

    // R9: a faulting walk leaves the previous result untouched
    begin
      logic [63:0] hr, hl;
      logic [5:0]  hp;
      lat_sel = 1;
      build(eas[1], 2, 9, 64'h0);
      run_walk(eas[1], RB, 13, 52);
      hr = real_addr; hl = leaf_entry; hp = page_size;
      mem[paddr[1]] = 64'h0;
      run_walk(eas[1], RB, 13, 52);
      chk("R9 fault_kind no entry", 64'(fault_kind), 64'd1);
      chk("R9 real_addr held", real_addr, hr);
      chk("R9 leaf_entry held", leaf_entry, hl);
      chk("R9 page_size held", 64'(page_size), 64'(hp));
      @(negedge clk);
      chk("R9 fault is a pulse", 64'(fault), 64'd0);
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R9 watchdog actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule